// File: doc/BRIEF.md
# Halt and Interrupt Entry Sequencer

This control block sits inside an 8-bit accumulator CPU core. It decides when the core stops at a HALT instruction, when it leaves that stopped state, and when it starts an interrupt acknowledge. At each instruction boundary the core gives it a strobe that marks the final T-state of the last machine cycle. At that point the block samples the maskable request level and a latched non-maskable request. It then updates the two interrupt-enable flip-flops and either enters the halt state, leaves it, or starts an acknowledge.

While the core is halted it keeps issuing real opcode fetch cycles. The block holds back the program-counter increment, so the byte after the HALT opcode is fetched again and again. It also tells the opcode latch to replace that byte with a NOP, and it drives the active-low halt acknowledge pin. When an interrupt is accepted, the program counter still holds the address one past the HALT. The block strobes a push of that unmodified value and supplies the restart address that matches the interrupt type.

Top module: `halt_irq_seq`

## Requirements
- R1: While reset is low, and after it is released, halt_n_o is 1, force_nop_o is 0, ack_req_o is 0 and both enable flip-flops read 0. Reset also ends an active halt state.
- R2: A sample point (instr_last_i=1) with halt_exec_i=1 and no interrupt accepted enters the halt state at that edge: halt_n_o=0 and force_nop_o=1.
- R3: pc_inc_o equals fetch_i while the core is not halted and not acknowledging. pc_inc_o is 0 whenever halt_n_o is 0.
- R4: The halt state persists through any number of sample points that carry no accepted interrupt.
- R5: A falling edge on nmi_n_i is latched. At the next sample point after the latching edge it is accepted whatever iff1 holds. Acceptance gives a one-cycle ack_req_o with ack_nmi_o=1 and vector_o=16'h0066, ends the halt state, copies iff1 into iff2 and clears iff1.
- R6: A sample point with int_n_i=0, iff1=1, no EI/DI strobe and no pending NMI accepts a maskable request. The result is ack_req_o=1 for one cycle with ack_nmi_o=0 and vector_o=16'h0038, the halt state ends, and both flip-flops are cleared.
- R7: With iff1=0 a low int_n_i has no effect: the halt state and the flip-flops are unchanged.
- R8: When an NMI is pending and int_n_i is low at the same sample point, only the non-maskable request is acknowledged.
- R9: push_ret_o pulses in exactly the acknowledge cycle. pc_inc_o is 0 in that cycle, so the pushed program counter is unmodified.
- R10: ei_i at a sample point sets iff1 and iff2, and di_i clears both. No maskable request is accepted at a sample point that carries either strobe, so the following instruction runs first.
- R11: Requests are acted on only at sample points. A low int_n_i while instr_last_i=0 starts nothing.
- R12: An accepted NMI clears its latch. A request held low does not cause a second acknowledge unless it goes high and falls again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_i | input | 1 | Current cycle is an opcode fetch that would advance the PC |
| instr_last_i | input | 1 | Last T-state of the last machine cycle (sample point) |
| halt_exec_i | input | 1 | Decoded HALT opcode, valid with its sample point |
| ei_i | input | 1 | EI instruction ends at this sample point |
| di_i | input | 1 | DI instruction ends at this sample point |
| int_n_i | input | 1 | Maskable request, active low, level sensed |
| nmi_n_i | input | 1 | Non-maskable request, active low, edge sensed |
| pc_inc_o | output | 1 | Program-counter increment enable |
| force_nop_o | output | 1 | Replace the fetched opcode with NOP |
| halt_n_o | output | 1 | Halt acknowledge, active low |
| ack_req_o | output | 1 | Start an interrupt acknowledge cycle |
| ack_nmi_o | output | 1 | Acknowledge type: 1 non-maskable, 0 maskable |
| push_ret_o | output | 1 | Push the current PC as the return address |
| vector_o | output | 16 | Restart address for the acknowledged request |
| iff1_o | output | 1 | Interrupt-enable flip-flop 1 |
| iff2_o | output | 1 | Interrupt-enable flip-flop 2 |

## Verification
The properties assume that all inputs are synchronous to clk. They also assume that halt_exec_i, ei_i and di_i are raised only together with instr_last_i, at most one of them at a time, and never while the core is halted, because a halted core decodes nothing. The stimulus changes inputs only on the falling clock edge and keeps every instruction strobe on a sample point. It drives each NMI low for at least one cycle before the sample point that should take it, and it never presents a new NMI edge in the same cycle as an acceptance.

// File: rtl/halt_irq_pkg.sv
package halt_irq_pkg;

    typedef struct packed {
        logic        halted;
        logic        iff1;
        logic        iff2;
        logic        ack;
        logic        ack_nmi;
        logic [15:0] vector;
    } seq_state_t;

endpackage

// File: rtl/nmi_edge_latch.sv
module nmi_edge_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_n_i,
    input  logic consume_i,
    output logic pending_o
);

    typedef struct packed {
        logic prev;
        logic pend;
    } edge_state_t;

    edge_state_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.prev = nmi_n_i;
        // a new falling edge always wins over a consume in the same cycle
        s_d.pend = (s_q.prev & ~nmi_n_i) | (s_q.pend & ~consume_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{prev: 1'b1, pend: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign pending_o = s_q.pend;

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter (
    input  logic sample_i,
    input  logic nmi_pend_i,
    input  logic int_n_i,
    input  logic iff1_i,
    input  logic block_i,
    output logic take_nmi_o,
    output logic take_int_o
);

    always_comb begin
        take_nmi_o = sample_i & nmi_pend_i;
        take_int_o = sample_i & ~nmi_pend_i & ~int_n_i & iff1_i & ~block_i;
    end

endmodule

// File: rtl/halt_irq_seq.sv
module halt_irq_seq #(
    parameter int          ADDR_W   = 16,
    parameter logic [15:0] NMI_ADDR = 16'h0066,
    parameter logic [15:0] INT_ADDR = 16'h0038
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_i,
    input  logic              instr_last_i,
    input  logic              halt_exec_i,
    input  logic              ei_i,
    input  logic              di_i,
    input  logic              int_n_i,
    input  logic              nmi_n_i,
    output logic              pc_inc_o,
    output logic              force_nop_o,
    output logic              halt_n_o,
    output logic              ack_req_o,
    output logic              ack_nmi_o,
    output logic              push_ret_o,
    output logic [ADDR_W-1:0] vector_o,
    output logic              iff1_o,
    output logic              iff2_o
);
    import halt_irq_pkg::*;

    seq_state_t st_d, st_q;
    logic       nmi_pend;
    logic       take_nmi;
    logic       take_int;
    logic       ei_di_block;

    assign ei_di_block = ei_i | di_i;

    nmi_edge_latch u_nmi (
        .clk       (clk),
        .rst_n     (rst_n),
        .nmi_n_i   (nmi_n_i),
        .consume_i (take_nmi),
        .pending_o (nmi_pend)
    );

    irq_arbiter u_arb (
        .sample_i   (instr_last_i),
        .nmi_pend_i (nmi_pend),
        .int_n_i    (int_n_i),
        .iff1_i     (st_q.iff1),
        .block_i    (ei_di_block),
        .take_nmi_o (take_nmi),
        .take_int_o (take_int)
    );

    always_comb begin
        st_d         = st_q;
        st_d.ack     = 1'b0;
        st_d.ack_nmi = 1'b0;
        if (instr_last_i) begin
            if (ei_i) begin
                st_d.iff1 = 1'b1;
                st_d.iff2 = 1'b1;
            end else if (di_i) begin
                st_d.iff1 = 1'b0;
                st_d.iff2 = 1'b0;
            end
            if (take_nmi) begin
                st_d.ack     = 1'b1;
                st_d.ack_nmi = 1'b1;
                st_d.halted  = 1'b0;
                st_d.iff2    = st_d.iff1;
                st_d.iff1    = 1'b0;
                st_d.vector  = NMI_ADDR;
            end else if (take_int) begin
                st_d.ack    = 1'b1;
                st_d.halted = 1'b0;
                st_d.iff1   = 1'b0;
                st_d.iff2   = 1'b0;
                st_d.vector = INT_ADDR;
            end else if (halt_exec_i) begin
                st_d.halted = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pc_inc_o    = fetch_i & ~st_q.halted & ~st_q.ack;
    assign force_nop_o = st_q.halted;
    assign halt_n_o    = ~st_q.halted;
    assign ack_req_o   = st_q.ack;
    assign ack_nmi_o   = st_q.ack_nmi;
    assign push_ret_o  = st_q.ack;
    assign vector_o    = st_q.vector[ADDR_W-1:0];
    assign iff1_o      = st_q.iff1;
    assign iff2_o      = st_q.iff2;

endmodule

// File: rtl/halt_irq_seq_chk.sv
module halt_irq_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        instr_last_i,
    input logic        pc_inc_o,
    input logic        halt_n_o,
    input logic        ack_req_o,
    input logic        ack_nmi_o,
    input logic        push_ret_o,
    input logic [15:0] vector_o,
    input logic        iff1_o,
    input logic        iff2_o
);

    a_r3_no_pc_inc_halted: assert property (@(posedge clk) disable iff (!rst_n)
        !halt_n_o |-> !pc_inc_o);

    a_r4_halt_holds_between_samples: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt_n_o && !instr_last_i) |=> !halt_n_o);

    a_r5_nmi_vector: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req_o && ack_nmi_o) |-> (vector_o == 16'h0066 && !iff1_o));

    a_r6_int_vector: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req_o && !ack_nmi_o) |-> (vector_o == 16'h0038 && !iff1_o && !iff2_o));

    a_r9_push_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
        ack_req_o |-> (push_ret_o && !pc_inc_o && halt_n_o));

    a_r11_ack_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_req_o) |-> $past(instr_last_i));

endmodule

bind halt_irq_seq halt_irq_seq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .instr_last_i (instr_last_i),
    .pc_inc_o     (pc_inc_o),
    .halt_n_o     (halt_n_o),
    .ack_req_o    (ack_req_o),
    .ack_nmi_o    (ack_nmi_o),
    .push_ret_o   (push_ret_o),
    .vector_o     (vector_o),
    .iff1_o       (iff1_o),
    .iff2_o       (iff2_o)
);

// File: tb/halt_irq_seq_tb_top.sv
module halt_irq_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int N_STEPS    = 18;

    // {last,halt,ei,di,int_n,nmi_n, halt_n,ack,ack_nmi,iff1,iff2}
    localparam logic [10:0] STEPS [N_STEPS] = '{
        11'b101001_10011,  // R10 EI sets both, blocks INT
        11'b000001_10011,  // R11 no sample point
        11'b110011_00011,  // R2 enter halt
        11'b100011_00011,  // R4 stays halted
        11'b100001_11000,  // R6 maskable exits halt
        11'b000011_10000,  // R6 ack lasts one cycle
        11'b110011_00000,  // R2 halt again
        11'b100001_00000,  // R7 INT masked, still halted
        11'b000010_00000,  // R5 NMI edge latched
        11'b100010_11100,  // R5 NMI accepted
        11'b100010_10000,  // R12 no repeat while held low
        11'b101011_10011,  // R10 EI
        11'b000010_10011,  // R8 NMI latched
        11'b100000_11101,  // R8 NMI wins over INT
        11'b100001_10001,  // R7 iff1 clear after NMI
        11'b100111_10000,  // R10 DI clears
        11'b101001_10011,  // R10 EI blocks INT at its own end
        11'b100101_10000   // R10 DI blocks INT too
    };
    localparam int STEP_REQ [N_STEPS] = '{10, 11, 2, 4, 6, 6, 2, 7, 5, 5, 12, 10, 8, 8, 7, 10, 10, 10};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_i = 1'b0, instr_last_i = 1'b0, halt_exec_i = 1'b0;
    logic        ei_i = 1'b0, di_i = 1'b0, int_n_i = 1'b1, nmi_n_i = 1'b1;
    logic        pc_inc_o, force_nop_o, halt_n_o, ack_req_o, ack_nmi_o, push_ret_o;
    logic [15:0] vector_o;
    logic        iff1_o, iff2_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    halt_irq_seq dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .fetch_i      (fetch_i),
        .instr_last_i (instr_last_i),
        .halt_exec_i  (halt_exec_i),
        .ei_i         (ei_i),
        .di_i         (di_i),
        .int_n_i      (int_n_i),
        .nmi_n_i      (nmi_n_i),
        .pc_inc_o     (pc_inc_o),
        .force_nop_o  (force_nop_o),
        .halt_n_o     (halt_n_o),
        .ack_req_o    (ack_req_o),
        .ack_nmi_o    (ack_nmi_o),
        .push_ret_o   (push_ret_o),
        .vector_o     (vector_o),
        .iff1_o       (iff1_o),
        .iff2_o       (iff2_o)
    );

    task automatic check(input int req, input string what, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic last, input logic hlt, input logic ei, input logic di,
                         input logic intn, input logic nmin);
        instr_last_i = last;
        halt_exec_i  = hlt;
        ei_i         = ei;
        di_i         = di;
        int_n_i      = intn;
        nmi_n_i      = nmin;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    initial begin
        // R1: reset state while reset is held
        repeat (2) @(negedge clk);
        check(1, "halt_n in reset", {15'd0, halt_n_o}, 16'd1);
        check(1, "ack/iff in reset", {13'd0, ack_req_o, iff1_o, iff2_o}, 16'd0);
        rst_n = 1'b1;
        step();
        check(1, "force_nop after reset", {15'd0, force_nop_o}, 16'd0);

        // R3: pc_inc follows fetch while running
        fetch_i = 1'b1;
        #1;
        check(3, "pc_inc running", {15'd0, pc_inc_o}, 16'd1);
        fetch_i = 1'b0;

        for (int i = 0; i < N_STEPS; i++) begin
            logic [10:0] v;
            v = STEPS[i];
            drive(v[10], v[9], v[8], v[7], v[6], v[5]);
            step();
            check(STEP_REQ[i], $sformatf("step %0d outputs", i),
                  {11'd0, halt_n_o, ack_req_o, ack_nmi_o, iff1_o, iff2_o}, {11'd0, v[4:0]});
            if (v[3]) begin
                check(9, $sformatf("step %0d push", i), {15'd0, push_ret_o}, 16'd1);
                check(STEP_REQ[i], $sformatf("step %0d vector", i), vector_o,
                      v[2] ? 16'h0066 : 16'h0038);
            end
        end

        // R3/R9: halted fetch gives no increment; ack cycle gives none either
        drive(1, 0, 1, 0, 1, 1);
        step();
        drive(1, 1, 0, 0, 1, 1);
        step();
        drive(0, 0, 0, 0, 1, 1);
        fetch_i = 1'b1;
        #1;
        check(3, "pc_inc while halted", {15'd0, pc_inc_o}, 16'd0);
        check(2, "force_nop while halted", {15'd0, force_nop_o}, 16'd1);
        drive(1, 0, 0, 0, 0, 1);
        step();
        check(9, "pc_inc in ack cycle", {15'd0, pc_inc_o}, 16'd0);
        check(9, "push in ack cycle", {15'd0, push_ret_o}, 16'd1);
        drive(0, 0, 0, 0, 1, 1);
        step();
        check(9, "push drops after ack", {15'd0, push_ret_o}, 16'd0);
        check(3, "pc_inc restored", {15'd0, pc_inc_o}, 16'd1);
        fetch_i = 1'b0;

        // R1: reset ends the halt state
        drive(1, 1, 0, 0, 1, 1);
        step();
        drive(0, 0, 0, 0, 1, 1);
        check(2, "halted before reset", {15'd0, halt_n_o}, 16'd0);
        rst_n = 1'b0;
        #1;
        check(1, "reset ends halt", {15'd0, halt_n_o}, 16'd1);
        step();
        rst_n = 1'b1;
        step();
        check(1, "iff after reset", {14'd0, iff1_o, iff2_o}, 16'd0);

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL R1 watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule